// File: doc/BRIEF.md
# Multimode Interleaver Write-Address Generator

This block produces the address streams for a bit-level block interleaver. It serves four modulation modes, each with one or more interleaver depths. Each clock cycle it presents one write address, one sequential read address and a flag that marks the final element of a block.

The write address is not taken from row and column counters. An accumulator adds an increment that depends on the mode to the previous address. For 16-QAM this increment alternates between two values, and for 64-QAM it cycles through three values. The point in that cycle where a row begins moves back one step on every new row, which yields the permutation the modulation needs.

Every block has 16 addresses per row. Row r begins at address r. The mode and depth are captured at clear and at each block boundary, and are held for the whole block.

Top module: `ilv_addr_gen`

## Requirements
- R1: While `clr` is high at a rising edge, the next outputs are `wr_addr`=0, `rd_addr`=0 and `blk_done`=0. The mode and depth selector present at that edge are captured for the block that follows.
- R2: Modulation type encoding is 00 BPSK, 01 QPSK, 10 16-QAM and 11 64-QAM. BPSK has depth 48 and a constant increment of 3, and its depth selector is ignored.
- R3: For QPSK, selector values 000 through 111 give depths 96, 144, 192, 288, 384, 432, 480 and 576. The matching constant increments are 6, 9, 12, 18, 24, 27, 30 and 36.
- R4: For 16-QAM, selector bits [1:0] 00 through 11 give depths 192, 288, 384 and 576, with increment pairs 13/11, 19/17, 25/23 and 37/35. Selector bit 2 is ignored. Increments alternate within a row, and odd rows begin with the second value of the pair.
- R5: For 64-QAM, selector bits [1:0] 00 through 11 give depths 288, 384, 432 and 576, with increment triples 20/17/17, 26/23/23, 29/26/26 and 38/35/35. Selector bit 2 is ignored. Increments cycle in order within a row. Row r begins at triple position (3 - r mod 3) mod 3.
- R6: Every row holds 16 write addresses, and row r begins at write address r.
- R7: `rd_addr` counts up by one per cycle from 0 to depth-1 and then returns to 0.
- R8: `blk_done` is high for exactly the one cycle in which the final address of a block is presented. In the next cycle both addresses are 0 and the increment cycle restarts at its first value.
- R9: A change of the mode or depth selector in the middle of a block has no effect until the next block boundary.
- R10: The write address always stays below the depth of the current block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous active-high clear |
| mod_type | input | 2 | Modulation mode |
| depth_sel | input | 3 | Depth selector |
| wr_addr | output | 10 | Permuted write address |
| rd_addr | output | 10 | Sequential read address |
| blk_done | output | 1 | High while the final address of a block is shown |

## Verification
A row restart and a block wrap happen in the same cycle when the final column of the final row is reached. At that point the write address must return to 0 instead of to the next row start, and the new configuration must be captured at that edge. The bench provokes this by running blocks back to back and by changing the selectors partway through a block. It checks that the next block starts at 0 and follows the new mode's sequence, and that `blk_done` is high only for that final element.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef struct packed {
    logic [5:0] rows;
    logic [1:0] period;
    logic [5:0] inc0;
    logic [5:0] inc1;
    logic [5:0] inc2;
  } cfg_t;

  function automatic cfg_t decode_cfg(input logic [1:0] m, input logic [2:0] s);
    cfg_t c;
    logic [5:0] base;
    base = 6'd3;
    c.period = 2'd1;
    case (m)
      2'b00: base = 6'd3;
      2'b01: begin
        case (s)
          3'd0: base = 6'd6;
          3'd1: base = 6'd9;
          3'd2: base = 6'd12;
          3'd3: base = 6'd18;
          3'd4: base = 6'd24;
          3'd5: base = 6'd27;
          3'd6: base = 6'd30;
          default: base = 6'd36;
        endcase
      end
      2'b10: begin
        c.period = 2'd2;
        case (s[1:0])
          2'd0: base = 6'd12;
          2'd1: base = 6'd18;
          2'd2: base = 6'd24;
          default: base = 6'd36;
        endcase
      end
      default: begin
        c.period = 2'd3;
        case (s[1:0])
          2'd0: base = 6'd18;
          2'd1: base = 6'd24;
          2'd2: base = 6'd27;
          default: base = 6'd36;
        endcase
      end
    endcase
    c.rows = base;
    case (c.period)
      2'd2: begin
        c.inc0 = base + 6'd1;
        c.inc1 = base - 6'd1;
        c.inc2 = base - 6'd1;
      end
      2'd3: begin
        c.inc0 = base + 6'd2;
        c.inc1 = base - 6'd1;
        c.inc2 = base - 6'd1;
      end
      default: begin
        c.inc0 = base;
        c.inc1 = base;
        c.inc2 = base;
      end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/ilv_cfg_reg.sv
module ilv_cfg_reg
  import ilv_pkg::*;
(
  input  logic       clk,
  input  logic       load,
  input  logic [1:0] mod_type,
  input  logic [2:0] depth_sel,
  output cfg_t       cfg
);
  always_ff @(posedge clk) begin
    if (load) cfg <= decode_cfg(mod_type, depth_sel);
  end
endmodule

// File: rtl/ilv_step_sel.sv
module ilv_step_sel
  import ilv_pkg::*;
(
  input  cfg_t       cfg,
  input  logic [1:0] phase,
  output logic [5:0] step
);
  always_comb begin
    case (phase)
      2'd0:    step = cfg.inc0;
      2'd1:    step = cfg.inc1;
      default: step = cfg.inc2;
    endcase
  end
endmodule

// File: rtl/ilv_rd_counter.sv
module ilv_rd_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         wrap,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (clr || wrap) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int COLS   = 16
) (
  input  logic              clk,
  input  logic              clr,
  input  logic [1:0]        mod_type,
  input  logic [2:0]        depth_sel,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              blk_done
);
  localparam int COL_W = $clog2(COLS);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [COL_W-1:0] COL_PRE  = COL_W'(COLS - 2);

  cfg_t              cfg_q;
  logic [COL_W-1:0]  col_q;
  logic [5:0]        row_q;
  logic [1:0]        ph_q, row_ph_q;
  logic [ADDR_W-1:0] row_start_q, wr_q;
  logic              done_q;
  logic [5:0]        step;
  logic              last_row, last_elem, pre_last, load_cfg;
  logic [1:0]        ph_next, row_ph_next;

  assign last_row  = (row_q == cfg_q.rows - 6'd1);
  assign last_elem = (col_q == COL_LAST) && last_row;
  assign pre_last  = (col_q == COL_PRE) && last_row;
  assign load_cfg  = clr || last_elem;
  assign ph_next     = (ph_q == cfg_q.period - 2'd1) ? 2'd0 : ph_q + 2'd1;
  assign row_ph_next = (row_ph_q == 2'd0) ? cfg_q.period - 2'd1 : row_ph_q - 2'd1;

  ilv_cfg_reg u_cfg (
    .clk(clk), .load(load_cfg), .mod_type(mod_type),
    .depth_sel(depth_sel), .cfg(cfg_q)
  );

  ilv_step_sel u_step (.cfg(cfg_q), .phase(ph_q), .step(step));

  ilv_rd_counter #(.W(ADDR_W)) u_rd (
    .clk(clk), .clr(clr), .wrap(last_elem), .cnt(rd_addr)
  );

  always_ff @(posedge clk) begin
    if (clr || last_elem) begin
      col_q       <= '0;
      row_q       <= '0;
      ph_q        <= 2'd0;
      row_ph_q    <= 2'd0;
      row_start_q <= '0;
      wr_q        <= '0;
      done_q      <= 1'b0;
    end else if (col_q == COL_LAST) begin
      col_q       <= '0;
      row_q       <= row_q + 6'd1;
      ph_q        <= row_ph_next;
      row_ph_q    <= row_ph_next;
      row_start_q <= row_start_q + 1'b1;
      wr_q        <= row_start_q + 1'b1;
      done_q      <= 1'b0;
    end else begin
      col_q  <= col_q + 1'b1;
      ph_q   <= ph_next;
      wr_q   <= wr_q + ADDR_W'(step);
      done_q <= pre_last;
    end
  end

  assign wr_addr  = wr_q;
  assign blk_done = done_q;
endmodule

// File: rtl/ilv_addr_gen_chk.sv
module ilv_addr_gen_chk
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int COLS   = 16
) (
  input logic              clk,
  input logic              clr,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              blk_done,
  input cfg_t              cfg
);
  logic seen_clr = 1'b0;
  always_ff @(posedge clk) if (clr) seen_clr <= 1'b1;

  a_r7_rd_step: assert property (@(posedge clk) disable iff (clr || !seen_clr)
    !blk_done |=> rd_addr == $past(rd_addr) + 1'b1);
  a_r8_done_wrap: assert property (@(posedge clk) disable iff (clr || !seen_clr)
    blk_done |=> (wr_addr == '0) && (rd_addr == '0));
  a_r8_done_single: assert property (@(posedge clk) disable iff (clr || !seen_clr)
    blk_done |=> !blk_done);
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (clr || !seen_clr)
    !blk_done |=> $stable(cfg));
  a_r10_wr_bound: assert property (@(posedge clk) disable iff (clr || !seen_clr)
    int'(wr_addr) < int'(cfg.rows) * COLS);
  a_r6_row_start: assert property (@(posedge clk) disable iff (clr || !seen_clr)
    (int'(rd_addr) % COLS == 0) |-> int'(wr_addr) == int'(rd_addr) / COLS);
endmodule

bind ilv_addr_gen ilv_addr_gen_chk #(.ADDR_W(ADDR_W), .COLS(COLS)) u_chk (
  .clk(clk), .clr(clr), .wr_addr(wr_addr), .rd_addr(rd_addr),
  .blk_done(blk_done), .cfg(cfg_q)
);

// File: tb/ilv_addr_gen_test.sv
module ilv_addr_gen_test;
  localparam int CLK_PERIOD = 10;
  int checks = 0;
  int failures = 0;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic [1:0] mod_type = 2'b00;
  logic [2:0] depth_sel = 3'b000;
  logic [9:0] wr_addr, rd_addr;
  logic       blk_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_addr_gen uut (
    .clk(clk), .clr(clr), .mod_type(mod_type), .depth_sel(depth_sel),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .blk_done(blk_done)
  );

  function automatic int m_rows(input logic [1:0] m, input logic [2:0] s);
    case (m)
      2'b00: return 3;
      2'b01: case (s) 0: return 6; 1: return 9; 2: return 12; 3: return 18;
               4: return 24; 5: return 27; 6: return 30; default: return 36; endcase
      2'b10: case (s[1:0]) 0: return 12; 1: return 18; 2: return 24; default: return 36; endcase
      default: case (s[1:0]) 0: return 18; 1: return 24; 2: return 27; default: return 36; endcase
    endcase
  endfunction

  function automatic int m_per(input logic [1:0] m);
    return (m == 2'b10) ? 2 : (m == 2'b11) ? 3 : 1;
  endfunction

  function automatic int m_inc(input logic [1:0] m, input logic [2:0] s, input int idx);
    int b = m_rows(m, s);
    if (m == 2'b10) return (idx == 0) ? b + 1 : b - 1;
    if (m == 2'b11) return (idx == 0) ? b + 2 : b - 1;
    return b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_clear(input logic [1:0] m, input logic [2:0] s);
    @(negedge clk); clr = 1'b1; mod_type = m; depth_sel = s;
    @(negedge clk); clr = 1'b0;
  endtask

  // Checks up to 'limit' elements of a block of mode m/s; at element chg_at drives cm/cs.
  task automatic check_block(input logic [1:0] m, input logic [2:0] s, input int limit,
                             input int chg_at, input logic [1:0] cm, input logic [2:0] cs,
                             input string req);
    int rows = m_rows(m, s);
    int per  = m_per(m);
    int depth = rows * 16;
    int k = 0;
    for (int r = 0; r < rows; r++) begin
      int ph = (per - (r % per)) % per;
      int a = r;
      for (int c = 0; c < 16; c++) begin
        if (k >= limit) return;
        chk(wr_addr == 10'(a), req, wr_addr, a);
        chk(rd_addr == 10'(k), "R7", rd_addr, k);
        chk(blk_done == (k == depth - 1), "R8", blk_done, k == depth - 1);
        if (k == chg_at) begin mod_type = cm; depth_sel = cs; end
        a += m_inc(m, s, ph);
        ph = (ph + 1) % per;
        k++;
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk); clr = 1'b1; mod_type = 2'b11; depth_sel = 3'b011;
    repeat (3) @(negedge clk);
    chk(wr_addr == 0, "R1 wr", wr_addr, 0);
    chk(rd_addr == 0, "R1 rd", rd_addr, 0);
    chk(blk_done == 0, "R1 done", blk_done, 0);
    clr = 1'b0;
  endtask

  task automatic t_modes();
    do_clear(2'b00, 3'b101); check_block(2'b00, 3'b101, 9999, -1, 0, 0, "R2");
    do_clear(2'b01, 3'b000); check_block(2'b01, 3'b000, 9999, -1, 0, 0, "R3");
    do_clear(2'b01, 3'b111); check_block(2'b01, 3'b111, 9999, -1, 0, 0, "R3");
    do_clear(2'b10, 3'b000); check_block(2'b10, 3'b000, 9999, -1, 0, 0, "R4");
    do_clear(2'b10, 3'b111); check_block(2'b10, 3'b011, 9999, -1, 0, 0, "R4");
    do_clear(2'b11, 3'b000); check_block(2'b11, 3'b000, 9999, -1, 0, 0, "R5");
    do_clear(2'b11, 3'b110); check_block(2'b11, 3'b010, 9999, -1, 0, 0, "R5");
  endtask

  task automatic t_spot();
    // R4 row 1 of 16-QAM depth 192 starts 1,12,25,36; R5 row 1 of 64-QAM depth 288 starts 1,18,38
    do_clear(2'b10, 3'b000);
    repeat (16) @(negedge clk);
    chk(wr_addr == 1, "R4 row1 a0", wr_addr, 1); @(negedge clk);
    chk(wr_addr == 12, "R4 row1 a1", wr_addr, 12); @(negedge clk);
    chk(wr_addr == 25, "R4 row1 a2", wr_addr, 25);
    do_clear(2'b11, 3'b000);
    repeat (16) @(negedge clk);
    chk(wr_addr == 1, "R5 row1 a0", wr_addr, 1); @(negedge clk);
    chk(wr_addr == 18, "R5 row1 a1", wr_addr, 18); @(negedge clk);
    chk(wr_addr == 38, "R5 row1 a2", wr_addr, 38);
  endtask

  task automatic t_boundary();
    // R9: switch at element 40 to BPSK; QPSK block continues, then BPSK block after wrap (R8, R6)
    do_clear(2'b01, 3'b000);
    check_block(2'b01, 3'b000, 9999, 40, 2'b00, 3'b000, "R9");
    check_block(2'b00, 3'b000, 9999, -1, 0, 0, "R8 R6");
    check_block(2'b00, 3'b000, 9999, 5, 2'b11, 3'b011, "R9");
    check_block(2'b11, 3'b011, 9999, -1, 0, 0, "R10 R5");
  endtask

  task automatic t_mid_clear();
    do_clear(2'b11, 3'b001);
    check_block(2'b11, 3'b001, 50, -1, 0, 0, "R1");
    do_clear(2'b10, 3'b001);
    check_block(2'b10, 3'b001, 9999, -1, 0, 0, "R1 R4");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_modes();
    t_spot();
    t_boundary();
    t_mid_clear();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule